// File: doc/BRIEF.md
# Packed Double-Precision Compare Stage

This block compares two vectors of IEEE 754 binary64 values lane by lane under a 5-bit predicate. It produces its result in one of three conventions, chosen per operation:

- **Legacy vector mode:** two lanes are compared and the lanes above them pass through from a supplied old destination.
- **Vector mode:** each lane inside the active length becomes a 64-bit all-ones or all-zeros word, and every lane beyond the length is cleared.
- **Mask mode:** one bit per lane is produced, zero-masked by a write mask, with an option to compare every lane against lane 0 of the second source.

The invalid-operation and denormal-operand indications of the participating lanes are merged into two sticky-free flags. An operation is accepted on a single-cycle `in_valid` strobe. Its results appear on registered outputs in the following cycle, together with a one-cycle `out_valid` pulse. The outputs hold their value until the next accepted operation. Decoding, operand fetch and result storage belong to the surrounding pipeline.

Top module: `fpcmp_packed`

## Requirements
- R1: `in_len` selects the active lane count: 0 selects 2 lanes, 1 selects 4 lanes, and 2 or 3 select 8 lanes (capped at `MAX_LANES`). Legacy mode always uses 2 lanes.
- R2: In vector mode (`in_mode` 1, or 3, which behaves identically), each lane below the active count is 64'hFFFF_FFFF_FFFF_FFFF when the predicate holds and 0 otherwise. All lanes at or above the count are 0, and `out_mask` is 0.
- R3: In legacy mode (`in_mode` 0), only predicate bits 2..0 select the predicate, with bits 4..3 treated as 0. Lanes 0 and 1 carry results, and every higher lane of `out_vec` equals the same lane of `in_old_dst`.
- R4: Predicate encoding:
  - Bits 1..0 choose equal, less, less-or-equal or unordered.
  - Bit 2 complements the whole outcome.
  - Bit 3 complements the outcome for unordered operands only.
  - The predicate is signaling when bits 1..0 are 1 or 2, and bit 4 flips that property.
- R5: In mask mode (`in_mode` 2), `out_mask[n]` is the lane-n outcome AND `in_wmask[n]`. Lanes with a clear mask bit give 0, and `out_vec` is 0.
- R6: In mask mode, `out_mask` bits at or above the active lane count are 0.
- R7: With `in_bcast` set in mask mode, every lane compares its first-source element against lane 0 of `in_src_b`. In the other modes `in_bcast` has no effect.
- R8: `out_invalid` is the OR, over participating lanes, of (any operand is a signaling NaN) or (the predicate is signaling and any operand is a NaN). `out_denormal` is the OR, over participating lanes, of (any operand has a zero exponent and a nonzero fraction). A lane participates when it is inside the length and, in mask mode, its mask bit is set.
- R9: Predicate bits 7..5 have no effect on any output.
- R10: Reset clears all outputs. `out_valid` is high exactly in the cycle after an `in_valid` cycle, and the outputs change only on accepted operations.
- R11: Ordered comparison is numeric: +0 and -0 are equal, negative values order below positive ones, and the infinities order at the extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept strobe for one operation |
| in_mode | input | 2 | 0 legacy, 1 vector, 2 mask, 3 vector |
| in_len | input | 2 | Active length code |
| in_pred | input | 8 | Predicate; bits 4..0 used |
| in_bcast | input | 1 | Broadcast lane 0 of source B (mask mode) |
| in_wmask | input | MAX_LANES | Per-lane write mask (mask mode) |
| in_src_a | input | 64*MAX_LANES | First source vector |
| in_src_b | input | 64*MAX_LANES | Second source vector |
| in_old_dst | input | 64*MAX_LANES | Previous destination for legacy merge |
| out_valid | output | 1 | Result pulse |
| out_vec | output | 64*MAX_LANES | Per-lane all-ones/all-zeros result |
| out_mask | output | MAX_LANES | Per-lane result bits |
| out_invalid | output | 1 | Merged invalid-operation flag |
| out_denormal | output | 1 | Merged denormal-operand flag |

## Verification
The bench builds the block with the default `MAX_LANES` of 8, so every length code is reachable. The 2- and 4-lane forms leave real upper lanes that must be cleared, merged or masked. That width lets one operation place NaNs, signed zeros, infinities and denormals in separate lanes, and all 32 predicates are swept across such a mixed vector. It also lets flag-raising operands be placed beyond the length or under a clear mask bit, which shows that those lanes contribute nothing to the flags.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int PRED_W = 5;

  typedef enum logic [1:0] {
    CMP_LEGACY = 2'd0,
    CMP_VECTOR = 2'd1,
    CMP_MASK   = 2'd2,
    CMP_VECALT = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    logic truth;
    logic invalid;
    logic denorm;
  } lane_res_t;

  function automatic logic f64_is_nan(input logic [FP_W-1:0] x);
    return (x[FP_W-2 -: EXP_W] == '1) && (x[FRAC_W-1:0] != '0);
  endfunction

  function automatic logic f64_is_snan(input logic [FP_W-1:0] x);
    return f64_is_nan(x) && !x[FRAC_W-1];
  endfunction

  function automatic logic f64_is_denorm(input logic [FP_W-1:0] x);
    return (x[FP_W-2 -: EXP_W] == '0) && (x[FRAC_W-1:0] != '0);
  endfunction

  function automatic logic f64_is_zero(input logic [FP_W-1:0] x);
    return x[FP_W-2:0] == '0;
  endfunction

  // ordered operands assumed
  function automatic logic f64_less(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b);
    if (f64_is_zero(a) && f64_is_zero(b)) return 1'b0;
    if (a[FP_W-1] != b[FP_W-1]) return a[FP_W-1];
    if (!a[FP_W-1]) return a[FP_W-2:0] < b[FP_W-2:0];
    return a[FP_W-2:0] > b[FP_W-2:0];
  endfunction

  function automatic logic f64_equal(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b);
    return (a == b) || (f64_is_zero(a) && f64_is_zero(b));
  endfunction

  function automatic logic pred_signals(input logic [PRED_W-1:0] p);
    return ((p[1:0] == 2'd1) || (p[1:0] == 2'd2)) ^ p[4];
  endfunction

  function automatic lane_res_t pred_eval(input logic [PRED_W-1:0] p,
                                          input logic [FP_W-1:0] a,
                                          input logic [FP_W-1:0] b);
    lane_res_t r;
    logic unord, lt, eq, base, ord_out, unord_out;
    unord = f64_is_nan(a) || f64_is_nan(b);
    lt    = f64_less(a, b);
    eq    = f64_equal(a, b);
    case (p[1:0])
      2'd0:    base = eq;
      2'd1:    base = lt;
      2'd2:    base = lt | eq;
      default: base = 1'b0;
    endcase
    ord_out   = base ^ p[2];
    unord_out = (p[1:0] == 2'd3) ^ p[2] ^ p[3];
    r.truth   = unord ? unord_out : ord_out;
    r.invalid = f64_is_snan(a) || f64_is_snan(b) || (pred_signals(p) && unord);
    r.denorm  = f64_is_denorm(a) || f64_is_denorm(b);
    return r;
  endfunction

endpackage

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
  import fpcmp_pkg::*;
#(
  parameter int MAX_LANES = 8
) (
  input  logic [1:0]            mode,
  input  logic [1:0]            len,
  input  logic [7:0]            pred,
  input  logic                  bcast,
  input  logic [MAX_LANES-1:0]  wmask,
  output logic [PRED_W-1:0]     eff_pred,
  output logic [MAX_LANES-1:0]  len_en,
  output logic [MAX_LANES-1:0]  part_en,
  output logic                  use_bcast,
  output logic                  sel_mask,
  output logic                  sel_legacy
);

  int lane_cnt;
  logic [2:0] unused_pred_hi;

  assign unused_pred_hi = pred[7:5];
  assign sel_mask   = (mode == CMP_MASK);
  assign sel_legacy = (mode == CMP_LEGACY);
  assign use_bcast  = sel_mask && bcast;
  assign eff_pred   = sel_legacy ? {2'b00, pred[2:0]} : pred[PRED_W-1:0];

  always_comb begin
    lane_cnt = 32'sd2 << len;
    if (sel_legacy) lane_cnt = 2;
    if (lane_cnt > MAX_LANES) lane_cnt = MAX_LANES;
    for (int i = 0; i < MAX_LANES; i++) begin
      len_en[i]  = (i < lane_cnt);
      part_en[i] = len_en[i] && (!sel_mask || wmask[i]);
    end
  end

endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
  import fpcmp_pkg::*;
(
  input  logic [PRED_W-1:0] pred,
  input  logic [FP_W-1:0]   op_a,
  input  logic [FP_W-1:0]   op_b,
  input  logic              enable,
  output logic              truth,
  output logic              flag_inv,
  output logic              flag_den
);

  lane_res_t res;

  assign res      = pred_eval(pred, op_a, op_b);
  assign truth    = res.truth;
  assign flag_inv = enable && res.invalid;
  assign flag_den = enable && res.denorm;

endmodule

// File: rtl/fpcmp_merge.sv
module fpcmp_merge
  import fpcmp_pkg::*;
#(
  parameter int MAX_LANES = 8,
  localparam int VEC_W = MAX_LANES * FP_W
) (
  input  logic [MAX_LANES-1:0] truth,
  input  logic [MAX_LANES-1:0] len_en,
  input  logic [MAX_LANES-1:0] part_en,
  input  logic [MAX_LANES-1:0] lane_inv,
  input  logic [MAX_LANES-1:0] lane_den,
  input  logic                 sel_mask,
  input  logic                 sel_legacy,
  input  logic [VEC_W-1:0]     old_dst,
  output logic [VEC_W-1:0]     vec_nxt,
  output logic [MAX_LANES-1:0] mask_nxt,
  output logic                 inv_nxt,
  output logic                 den_nxt
);

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_word
    always_comb begin
      if (sel_mask)
        vec_nxt[g*FP_W +: FP_W] = '0;
      else if (len_en[g])
        vec_nxt[g*FP_W +: FP_W] = {FP_W{truth[g]}};
      else if (sel_legacy)
        vec_nxt[g*FP_W +: FP_W] = old_dst[g*FP_W +: FP_W];
      else
        vec_nxt[g*FP_W +: FP_W] = '0;
    end
  end

  assign mask_nxt = sel_mask ? (truth & part_en) : '0;
  assign inv_nxt  = |lane_inv;
  assign den_nxt  = |lane_den;

endmodule

// File: rtl/fpcmp_packed.sv
module fpcmp_packed
  import fpcmp_pkg::*;
#(
  parameter int MAX_LANES = 8,
  localparam int VEC_W = MAX_LANES * FP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_mode,
  input  logic [1:0]           in_len,
  input  logic [7:0]           in_pred,
  input  logic                 in_bcast,
  input  logic [MAX_LANES-1:0] in_wmask,
  input  logic [VEC_W-1:0]     in_src_a,
  input  logic [VEC_W-1:0]     in_src_b,
  input  logic [VEC_W-1:0]     in_old_dst,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     out_vec,
  output logic [MAX_LANES-1:0] out_mask,
  output logic                 out_invalid,
  output logic                 out_denormal
);

  logic [PRED_W-1:0]    eff_pred;
  logic [MAX_LANES-1:0] len_en, part_en, lane_truth, lane_inv, lane_den;
  logic                 use_bcast, sel_mask, sel_legacy;
  logic [VEC_W-1:0]     vec_nxt;
  logic [MAX_LANES-1:0] mask_nxt;
  logic                 inv_nxt, den_nxt;

  fpcmp_ctrl #(.MAX_LANES(MAX_LANES)) i_ctrl (
    .mode(in_mode), .len(in_len), .pred(in_pred), .bcast(in_bcast),
    .wmask(in_wmask), .eff_pred(eff_pred), .len_en(len_en),
    .part_en(part_en), .use_bcast(use_bcast), .sel_mask(sel_mask),
    .sel_legacy(sel_legacy)
  );

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    logic [FP_W-1:0] b_sel;
    assign b_sel = use_bcast ? in_src_b[FP_W-1:0] : in_src_b[g*FP_W +: FP_W];
    fpcmp_lane i_lane (
      .pred(eff_pred), .op_a(in_src_a[g*FP_W +: FP_W]), .op_b(b_sel),
      .enable(part_en[g]), .truth(lane_truth[g]),
      .flag_inv(lane_inv[g]), .flag_den(lane_den[g])
    );
  end

  fpcmp_merge #(.MAX_LANES(MAX_LANES)) i_merge (
    .truth(lane_truth), .len_en(len_en), .part_en(part_en),
    .lane_inv(lane_inv), .lane_den(lane_den), .sel_mask(sel_mask),
    .sel_legacy(sel_legacy), .old_dst(in_old_dst), .vec_nxt(vec_nxt),
    .mask_nxt(mask_nxt), .inv_nxt(inv_nxt), .den_nxt(den_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_vec      <= '0;
      out_mask     <= '0;
      out_invalid  <= 1'b0;
      out_denormal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec      <= vec_nxt;
        out_mask     <= mask_nxt;
        out_invalid  <= inv_nxt;
        out_denormal <= den_nxt;
      end
    end
  end

endmodule

// File: rtl/fpcmp_packed_chk.sv
module fpcmp_packed_chk #(
  parameter int MAX_LANES = 8,
  localparam int VEC_W = MAX_LANES * 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [1:0]           in_mode,
  input logic [1:0]           in_len,
  input logic [MAX_LANES-1:0] in_wmask,
  input logic [VEC_W-1:0]     in_old_dst,
  input logic [MAX_LANES-1:0] lane_inv,
  input logic                 out_valid,
  input logic [VEC_W-1:0]     out_vec,
  input logic [MAX_LANES-1:0] out_mask,
  input logic                 out_invalid
);

  logic [MAX_LANES-1:0] lim_now;
  always_comb begin
    lim_now = '0;
    for (int i = 0; i < MAX_LANES; i++)
      if (i < (32'sd2 << in_len)) lim_now[i] = 1'b1;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_vec) && $stable(out_mask))); // R10
  AST_LEGACY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd0) |=> out_vec[VEC_W-1:128] == $past(in_old_dst[VEC_W-1:128])); // R3
  AST_MASK_ZEROING: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd2) |=> (out_mask & ~$past(in_wmask)) == '0); // R5
  AST_MASK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd2) |=> (out_mask & ~$past(lim_now)) == '0); // R6
  AST_VEC_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode != 2'd2) |=> out_mask == '0); // R2
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_invalid == $past(|lane_inv)); // R8

endmodule

bind fpcmp_packed fpcmp_packed_chk #(.MAX_LANES(MAX_LANES)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
  .in_len(in_len), .in_wmask(in_wmask), .in_old_dst(in_old_dst),
  .lane_inv(lane_inv), .out_valid(out_valid), .out_vec(out_vec),
  .out_mask(out_mask), .out_invalid(out_invalid)
);

// File: tb/test_fpcmp_packed.sv
module test_fpcmp_packed;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int VW = NL * 64;

  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] HALF = 64'h3FE0_0000_0000_0000;
  localparam logic [63:0] NEG1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] DEN  = 64'h0000_0000_0000_0001;

  logic clk = 0, rst_n = 0, in_valid = 0, in_bcast = 0;
  logic [1:0] in_mode = 0, in_len = 0;
  logic [7:0] in_pred = 0;
  logic [NL-1:0] in_wmask = 0;
  logic [VW-1:0] in_src_a = 0, in_src_b = 0, in_old_dst = 0;
  logic out_valid, out_invalid, out_denormal;
  logic [VW-1:0] out_vec;
  logic [NL-1:0] out_mask;

  int checks = 0, failures = 0;
  logic [63:0] sa [NL], sb [NL], so [NL];
  logic [VW-1:0] e_vec;
  logic [NL-1:0] e_mask;
  logic e_inv, e_den;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcmp_packed #(.MAX_LANES(NL)) i_fpcmp_packed (.*);

  function automatic logic [4:0] tbl(input logic [4:0] p); // {lt,eq,gt,un,sig}
    case (p)
      5'h00: return 5'b01000; 5'h01: return 5'b10001; 5'h02: return 5'b11001; 5'h03: return 5'b00010;
      5'h04: return 5'b10110; 5'h05: return 5'b01111; 5'h06: return 5'b00111; 5'h07: return 5'b11100;
      5'h08: return 5'b01010; 5'h09: return 5'b10011; 5'h0A: return 5'b11011; 5'h0B: return 5'b00000;
      5'h0C: return 5'b10100; 5'h0D: return 5'b01101; 5'h0E: return 5'b00101; 5'h0F: return 5'b11110;
      5'h10: return 5'b01001; 5'h11: return 5'b10000; 5'h12: return 5'b11000; 5'h13: return 5'b00011;
      5'h14: return 5'b10111; 5'h15: return 5'b01110; 5'h16: return 5'b00110; 5'h17: return 5'b11101;
      5'h18: return 5'b01011; 5'h19: return 5'b10010; 5'h1A: return 5'b11010; 5'h1B: return 5'b00001;
      5'h1C: return 5'b10101; 5'h1D: return 5'b01100; 5'h1E: return 5'b00100; default: return 5'b11111;
    endcase
  endfunction

  function automatic logic isnan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  // expected values from the requirements
  task automatic model();
    int cnt;
    logic [4:0] p, t;
    logic [63:0] a, b;
    logic lt, eq, gt, un, res, part;
    real ra, rb;
    cnt = (in_mode == 0) ? 2 : (in_len == 0) ? 2 : (in_len == 1) ? 4 : 8;
    p = (in_mode == 0) ? {2'b00, in_pred[2:0]} : in_pred[4:0];
    t = tbl(p);
    e_vec = '0; e_mask = '0; e_inv = 0; e_den = 0;
    for (int n = 0; n < NL; n++) begin
      a = sa[n];
      b = (in_mode == 2 && in_bcast) ? sb[0] : sb[n];
      un = isnan(a) || isnan(b);
      lt = 0; eq = 0; gt = 0;
      if (!un) begin
        ra = $bitstoreal(a); rb = $bitstoreal(b);
        lt = ra < rb; eq = ra == rb; gt = ra > rb;
      end
      res = (lt & t[4]) | (eq & t[3]) | (gt & t[2]) | (un & t[1]);
      part = (n < cnt) && (in_mode != 2 || in_wmask[n]);
      if (in_mode == 2) e_mask[n] = part & res;
      else if (n < cnt) e_vec[n*64 +: 64] = {64{res}};
      else if (in_mode == 0) e_vec[n*64 +: 64] = so[n];
      if (part) begin
        if ((isnan(a) && !a[51]) || (isnan(b) && !b[51]) || (t[0] && un)) e_inv = 1;
        if ((a[62:52] == 0 && a[51:0] != 0) || (b[62:52] == 0 && b[51:0] != 0)) e_den = 1;
      end
    end
  endtask

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input string tag);
    for (int n = 0; n < NL; n++) begin
      in_src_a[n*64 +: 64] = sa[n];
      in_src_b[n*64 +: 64] = sb[n];
      in_old_dst[n*64 +: 64] = so[n];
    end
    model();
    in_valid = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(tag, VW'(out_valid), VW'(1'b1), "out_valid");
    chk(tag, out_vec, e_vec, "out_vec");
    chk(tag, VW'(out_mask), VW'(e_mask), "out_mask");
    chk(tag, VW'(out_invalid), VW'(e_inv), "out_invalid");
    chk(tag, VW'(out_denormal), VW'(e_den), "out_denormal");
  endtask

  task automatic set_mixed();
    sa[0] = ONE;  sb[0] = TWO;
    sa[1] = TWO;  sb[1] = ONE;
    sa[2] = ONE;  sb[2] = ONE;
    sa[3] = QNAN; sb[3] = ONE;
    sa[4] = NZ;   sb[4] = PZ;
    sa[5] = NINF; sb[5] = NEG1;
    sa[6] = NEG1; sb[6] = HALF;
    sa[7] = PINF; sb[7] = PINF;
    for (int n = 0; n < NL; n++) so[n] = 64'hA5A5_0000_0000_0000 | 64'(n);
  endtask

  task automatic t_reset();
    chk("R10", VW'(out_valid), '0, "reset valid");
    chk("R10", out_vec, '0, "reset vec");
    chk("R10", VW'({out_mask, out_invalid, out_denormal}), '0, "reset mask/flags");
  endtask

  task automatic t_lengths(); // R1 R2
    set_mixed();
    in_bcast = 1;
    for (int m = 1; m <= 3; m += 2)
      for (int l = 0; l < 4; l++) begin
        in_mode = 2'(m); in_len = 2'(l); in_pred = 8'h02;
        run_op("R1");
      end
    in_len = 2; in_pred = 8'h0E; run_op("R2");
    in_bcast = 0;
  endtask

  task automatic t_legacy(); // R3 R9
    set_mixed();
    in_mode = 0; in_len = 2; in_pred = 8'hF9; run_op("R3");
    in_pred = 8'h03; sa[0] = QNAN; run_op("R3");
  endtask

  task automatic t_sweep(); // R4 R11 R8
    set_mixed();
    in_wmask = '1; in_len = 2;
    for (int p = 0; p < 32; p++) begin
      in_mode = 2; in_pred = 8'(p); run_op("R4");
    end
    in_mode = 1;
    for (int p = 0; p < 32; p += 5) begin
      in_pred = 8'(p); run_op("R11");
    end
  endtask

  task automatic t_reserved(); // R9
    set_mixed();
    in_mode = 1; in_len = 2;
    for (int p = 0; p < 8; p++) begin
      in_pred = 8'(p * 32 + 1); run_op("R9");
    end
  endtask

  task automatic t_mask(); // R5 R6
    set_mixed();
    in_mode = 2; in_pred = 8'h0F;
    in_len = 1; in_wmask = 8'hA5; run_op("R5");
    in_len = 0; in_wmask = 8'hFF; run_op("R6");
    in_len = 2; in_wmask = 8'h00; run_op("R5");
  endtask

  task automatic t_bcast(); // R7
    for (int n = 0; n < NL; n++) begin sa[n] = (n % 2) ? TWO : HALF; sb[n] = (n % 3) ? NEG1 : PINF; end
    sb[0] = ONE;
    in_mode = 2; in_len = 2; in_wmask = '1; in_pred = 8'h01; in_bcast = 1; run_op("R7");
    in_mode = 1; run_op("R7");
    in_bcast = 0;
  endtask

  task automatic t_flags(); // R8
    for (int n = 0; n < NL; n++) begin sa[n] = ONE; sb[n] = TWO; end
    in_mode = 2; in_len = 1; in_pred = 8'h00;
    sa[2] = SNAN; sa[5] = DEN; in_wmask = 8'hFB; run_op("R8");
    in_wmask = 8'hFF; run_op("R8");
    sa[2] = QNAN; in_pred = 8'h00; run_op("R8");
    in_pred = 8'h10; run_op("R8");
    sa[2] = ONE; sb[1] = DEN; in_mode = 1; in_len = 0; run_op("R8");
  endtask

  task automatic t_hold(); // R10
    logic [VW-1:0] v; logic [NL-1:0] m;
    v = out_vec; m = out_mask;
    in_pred = 8'h0F; in_mode = 1; in_src_a = '1;
    @(posedge clk); @(negedge clk);
    chk("R10", VW'(out_valid), '0, "valid pulse");
    chk("R10", out_vec, v, "hold vec");
    chk("R10", VW'(out_mask), VW'(m), "hold mask");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_lengths();
    t_hold();
    t_legacy();
    t_sweep();
    t_reserved();
    t_mask();
    t_hold();
    t_bcast();
    t_flags();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule